// File: doc/BRIEF.md
# Pulse-Width Serial Timestamp Encoder

This block turns a 32-bit timestamp into a train of pulses on one line, so that a single time-to-digital converter channel can capture the whole value as a series of edge times. A frame is 32 fixed slots of 8 clock cycles each. At 40 MHz that is a 200 ns slot and a 6.4 us frame. Every slot opens with a rising edge. The bit value is carried by how long the line stays high: two cycles for a one and one cycle for a zero. The line is then low for the rest of the slot.

The host presents a word on the parallel input and pulses the load strobe. If the encoder is idle, it captures the word and begins sending at once, most significant bit first, and it holds the busy flag high until the last slot has ended. A load strobe that arrives during a frame is dropped. The serial line is driven as several identical copies from separate flops, which all change on the same clock edge. The reset input is asserted asynchronously and released synchronously inside the block.

Top module: `ts_pulse_encoder`

## Requirements
- R1: While reset is asserted, and until the first accepted load, busy is 0 and every serial output is 0, even if load is held high during reset.
- R2: A load sampled high while busy is 0 captures the word. On that same clock edge busy goes to 1 and the serial outputs go high to open the first slot.
- R3: Each frame consists of 32 slots of 8 clock cycles each. Every slot begins with a low-to-high transition on the serial outputs.
- R4: The pulse at the start of a slot is high for 2 cycles when the bit is 1 and for 1 cycle when the bit is 0. The outputs are low for the rest of the slot.
- R5: Slot 0 carries bit 31 of the captured word and slot 31 carries bit 0, so the word is sent most significant bit first.
- R6: Busy is 1 for exactly 256 cycles after the load edge. It falls on the edge that ends the last slot.
- R7: A load strobe sampled while busy is 1 is ignored. The word being sent, and the timing of its slots, are unchanged.
- R8: All serial output copies are identical in every cycle.
- R9: The serial outputs are 0 whenever busy is 0.
- R10: A load sampled on the first cycle in which busy is 0 starts a new frame with no extra gap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Encoder clock (40 MHz nominal) |
| rst_n | input | 1 | Active-low reset; asserted asynchronously, released synchronously inside the block |
| stamp_i | input | 32 | Timestamp word to be sent |
| load_i | input | 1 | Load strobe; sampled on the rising clock edge |
| busy_o | output | 1 | High while a frame is being sent |
| ser_o | output | 2 | Identical copies of the serial pulse train |

## Verification
The bench sends all-zero and all-one words, alternating patterns, patterns with only the end bits set, every walking-one position, and a set of arithmetic words. It checks every cycle of each frame against a pulse pattern it computes from the word, and it decodes the widths back into a word. If the bit order were reversed, the decoded word would come back mirrored. If the one-width and zero-width were swapped, the decoded word would come back inverted.

Some frames receive a load strobe partway through, with a different word on the input. A design that did not guard the load would restart the frame or switch to the new word.

Some frames are loaded on the first idle cycle after the previous frame. A busy flag that fell one cycle late, or a slot count that was off by one, shows up at the frame boundary as a missing or extra slot.

// File: rtl/ts_enc_pkg.sv
package ts_enc_pkg;

  // Default frame geometry: 32 bits, 8-cycle slots, 2-cycle one, 1-cycle zero.
  localparam int unsigned DEF_WORD_W   = 32;
  localparam int unsigned DEF_SLOT_CYC = 8;
  localparam int unsigned DEF_ONE_CYC  = 2;
  localparam int unsigned DEF_ZERO_CYC = 1;
  localparam int unsigned DEF_COPIES   = 2;

  // Number of cycles the line stays high for a given bit value.
  function automatic int unsigned high_cycles(input logic bit_val,
                                              input int unsigned one_cyc,
                                              input int unsigned zero_cyc);
    return bit_val ? one_cyc : zero_cyc;
  endfunction

endpackage

// File: rtl/ts_rst_sync.sv
module ts_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= {stage_q[0], 1'b1};
    end
  end

  assign rst_sync_n = stage_q[1];

endmodule

// File: rtl/ts_slot_timer.sv
module ts_slot_timer #(
  parameter int unsigned WORD_W   = ts_enc_pkg::DEF_WORD_W,
  parameter int unsigned SLOT_CYC = ts_enc_pkg::DEF_SLOT_CYC,
  localparam int unsigned PH_W    = $clog2(SLOT_CYC),
  localparam int unsigned IDX_W   = $clog2(WORD_W)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  output logic            busy_o,
  output logic            busy_nxt_o,
  output logic [PH_W-1:0] phase_o,
  output logic [PH_W-1:0] phase_nxt_o,
  output logic            advance_o
);

  localparam logic [PH_W-1:0]  PH_LAST  = PH_W'(SLOT_CYC - 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(WORD_W - 1);

  logic             busy_q, busy_n;
  logic [PH_W-1:0]  phase_q, phase_n;
  logic [IDX_W-1:0] idx_q, idx_n;
  logic             adv;
  logic             tick_en;

  // Next-state logic
  always_comb begin
    busy_n  = busy_q;
    phase_n = phase_q;
    idx_n   = idx_q;
    adv     = 1'b0;
    if (start_i) begin
      busy_n  = 1'b1;
      phase_n = '0;
      idx_n   = '0;
    end else if (busy_q) begin
      if (phase_q == PH_LAST) begin
        phase_n = '0;
        if (idx_q == IDX_LAST) begin
          busy_n = 1'b0;
        end else begin
          idx_n = idx_q + 1'b1;
          adv   = 1'b1;
        end
      end else begin
        phase_n = phase_q + 1'b1;
      end
    end
  end

  assign tick_en = start_i | busy_q;

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      phase_q <= '0;
      idx_q   <= '0;
    end else if (tick_en) begin
      busy_q  <= busy_n;
      phase_q <= phase_n;
      idx_q   <= idx_n;
    end
  end

  assign busy_o      = busy_q;
  assign busy_nxt_o  = busy_n;
  assign phase_o     = phase_q;
  assign phase_nxt_o = phase_n;
  assign advance_o   = adv;

  // R3
  phase_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !start_i && phase_q != PH_LAST) |=> (phase_q == $past(phase_q) + 1'b1));

  // R6
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> ($past(phase_q) == PH_LAST && $past(idx_q) == IDX_LAST));

endmodule

// File: rtl/ts_word_shifter.sv
module ts_word_shifter #(
  parameter int unsigned WORD_W = ts_enc_pkg::DEF_WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              shift_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              msb_nxt_o
);

  logic [WORD_W-1:0] sh_q, sh_n;
  logic              sh_en;

  always_comb begin
    sh_n = sh_q;
    if (load_i) begin
      sh_n = word_i;
    end else if (shift_i) begin
      sh_n = {sh_q[WORD_W-2:0], 1'b0};
    end
  end

  assign sh_en = load_i | shift_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
    end else if (sh_en) begin
      sh_q <= sh_n;
    end
  end

  assign msb_nxt_o = sh_n[WORD_W-1];

  // R7
  hold_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !shift_i) |=> $stable(sh_q));

endmodule

// File: rtl/ts_pulse_shaper.sv
module ts_pulse_shaper #(
  parameter int unsigned SLOT_CYC = ts_enc_pkg::DEF_SLOT_CYC,
  parameter int unsigned ONE_CYC  = ts_enc_pkg::DEF_ONE_CYC,
  parameter int unsigned ZERO_CYC = ts_enc_pkg::DEF_ZERO_CYC,
  parameter int unsigned COPIES   = ts_enc_pkg::DEF_COPIES,
  localparam int unsigned PH_W    = $clog2(SLOT_CYC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy_i,
  input  logic              busy_nxt_i,
  input  logic [PH_W-1:0]   phase_i,
  input  logic [PH_W-1:0]   phase_nxt_i,
  input  logic              bit_nxt_i,
  output logic [COPIES-1:0] ser_o
);

  localparam logic [PH_W-1:0] ONE_LEN = PH_W'(ONE_CYC);

  logic       level_n;
  logic [PH_W-1:0] hi_len;

  always_comb begin
    hi_len  = PH_W'(ts_enc_pkg::high_cycles(bit_nxt_i, ONE_CYC, ZERO_CYC));
    level_n = busy_nxt_i && (phase_nxt_i < hi_len);
  end

  for (genvar c = 0; c < COPIES; c++) begin : g_copy
    logic ser_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ser_q <= 1'b0;
      end else begin
        ser_q <= level_n;
      end
    end
    assign ser_o[c] = ser_q;
  end

  // R9
  idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_i |-> (ser_o == '0));

  // R4
  tail_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_i >= ONE_LEN) |-> (ser_o == '0));

  // R3
  slot_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && phase_i == '0) |-> (ser_o == '1));

  // R8
  copy_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_o == '0) || (ser_o == '1));

endmodule

// File: rtl/ts_pulse_encoder.sv
module ts_pulse_encoder #(
  parameter int unsigned WORD_W   = ts_enc_pkg::DEF_WORD_W,
  parameter int unsigned SLOT_CYC = ts_enc_pkg::DEF_SLOT_CYC,
  parameter int unsigned ONE_CYC  = ts_enc_pkg::DEF_ONE_CYC,
  parameter int unsigned ZERO_CYC = ts_enc_pkg::DEF_ZERO_CYC,
  parameter int unsigned COPIES   = ts_enc_pkg::DEF_COPIES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] stamp_i,
  input  logic              load_i,
  output logic              busy_o,
  output logic [COPIES-1:0] ser_o
);

  localparam int unsigned PH_W = $clog2(SLOT_CYC);

  logic            rst_int_n;
  logic            busy_q, busy_n;
  logic [PH_W-1:0] phase_q, phase_n;
  logic            advance;
  logic            start;
  logic            msb_n;

  ts_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  assign start = load_i & ~busy_q;

  ts_slot_timer #(.WORD_W(WORD_W), .SLOT_CYC(SLOT_CYC)) u_timer (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .start_i     (start),
    .busy_o      (busy_q),
    .busy_nxt_o  (busy_n),
    .phase_o     (phase_q),
    .phase_nxt_o (phase_n),
    .advance_o   (advance)
  );

  ts_word_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .load_i    (start),
    .shift_i   (advance),
    .word_i    (stamp_i),
    .msb_nxt_o (msb_n)
  );

  ts_pulse_shaper #(
    .SLOT_CYC (SLOT_CYC),
    .ONE_CYC  (ONE_CYC),
    .ZERO_CYC (ZERO_CYC),
    .COPIES   (COPIES)
  ) u_shape (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .busy_i      (busy_q),
    .busy_nxt_i  (busy_n),
    .phase_i     (phase_q),
    .phase_nxt_i (phase_n),
    .bit_nxt_i   (msb_n),
    .ser_o       (ser_o)
  );

  assign busy_o = busy_q;

  // R2
  load_start_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (load_i && !busy_o) |=> (busy_o && ser_o == '1));

endmodule

// File: tb/test_ts_pulse_encoder.sv
`timescale 1ns/1ps
module test_ts_pulse_encoder;

  localparam int W    = 32;
  localparam int SLOT = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          load;
  logic [W-1:0]  stamp;
  logic          busy;
  logic [1:0]    ser;

  int  vecs = 0;
  int  errs = 0;
  bit  finished = 1'b0;

  always #2.5 clk = ~clk;

  ts_pulse_encoder i_ts_pulse_encoder (
    .clk     (clk),
    .rst_n   (rst_n),
    .stamp_i (stamp),
    .load_i  (load),
    .busy_o  (busy),
    .ser_o   (ser)
  );

  task automatic chk(input bit ok, input string req,
                     input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Expects to be entered at a negative edge.
  task automatic frame(input logic [31:0] w, input bit stray, input string tag);
    logic [31:0] dec;
    int          hi;
    load  = 1'b1;
    stamp = w;
    @(negedge clk);
    load  = 1'b0;
    stamp = ~w;
    chk(busy == 1'b1 && ser == 2'b11, {tag, " frame start busy/ser"},
        {29'd0, busy, ser}, 32'd7);
    dec = '0;
    hi  = 0;
    for (int k = 0; k < W * SLOT; k++) begin
      int ph;
      int b;
      bit e;
      ph = k % SLOT;
      b  = W - 1 - k / SLOT;
      e  = (ph == 0) || (ph == 1 && w[b]);
      chk(busy == 1'b1, "R6 busy during frame", {31'd0, busy}, 32'd1);
      chk(ser[0] == e, "R4 pulse level (R3 slot grid)", {31'd0, ser[0]}, {31'd0, e});
      chk(ser[1] == ser[0], "R8 copies equal", {31'd0, ser[1]}, {31'd0, ser[0]});
      if (ser[0]) hi++;
      if (ph == SLOT - 1) begin
        dec = {dec[30:0], hi == 2};
        hi  = 0;
      end
      if (stray && k == 100) begin
        load  = 1'b1;
        stamp = w ^ 32'h1234_5678;
      end
      if (stray && k == 101) load = 1'b0;
      @(negedge clk);
    end
    chk(dec == w, "R5 decoded word msb first", dec, w);
    if (stray) chk(dec == w, "R7 stray load ignored", dec, w);
    chk(busy == 1'b0, "R6 busy low after last slot", {31'd0, busy}, 32'd0);
    chk(ser == 2'b00, "R9 line low after frame", {30'd0, ser}, 32'd0);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      stamp = stamp + 32'h0101_0101;
      chk(busy == 1'b0 && ser == 2'b00, "R9 idle low",
          {29'd0, busy, ser}, 32'd0);
      @(negedge clk);
    end
  endtask

  initial begin
    logic [31:0] lcg;
    rst_n = 1'b0;
    load  = 1'b1;
    stamp = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    chk(busy == 1'b0 && ser == 2'b00, "R1 reset state", {29'd0, busy, ser}, 32'd0);
    rst_n = 1'b1;
    load  = 1'b0;
    repeat (4) @(negedge clk);
    chk(busy == 1'b0 && ser == 2'b00, "R1 idle after reset", {29'd0, busy, ser}, 32'd0);

    frame(32'h0000_0000, 1'b0, "R2");
    idle(3);
    frame(32'hFFFF_FFFF, 1'b1, "R2");
    idle(2);
    frame(32'hA5A5_A5A5, 1'b0, "R2");
    frame(32'h5A5A_5A5A, 1'b0, "R10");
    idle(1);
    frame(32'h8000_0001, 1'b1, "R2");
    frame(32'h7FFF_FFFE, 1'b1, "R10");
    idle(2);
    for (int i = 0; i < W; i++) begin
      frame(32'h1 << i, (i % 4) == 0, (i % 2) ? "R10" : "R2");
    end
    idle(2);
    lcg = 32'h1357_9BDF;
    for (int i = 0; i < 10; i++) begin
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      frame(lcg, (i % 3) == 1, "R10");
    end
    idle(4);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      vecs++;
      errs++;
      $display("FAIL watchdog (all requirements) actual=%0d expected=%0d", 150000, 0);
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

endmodule